// File: doc/BRIEF.md
# Bitwise Taint-Tracking Shadow Unit

This combinational unit evaluates one bitwise operation on two W-bit operands and, alongside the data result, produces a per-bit shadow vector that marks which result bits are tainted. Each data input carries its own taint vector. A taint bit on the result is set exactly when some combination of flips of the tainted input bits could change that result bit. An input whose value cannot reach the output, because the other side blocks it, therefore contributes no taint. A constant or untainted input never creates taint.

A 4-bit opcode picks among three kinds of operation. The first kind is the AND-like operations: AND, NAND, OR, NOR, AND-with-inverted-B and OR-with-inverted-B. The second is the transparent ones: XOR, XNOR, NOT and BUF. The third is the two multiplexers, one with a single select bit spread across the whole width and one with a per-bit select. A tag-injection operation passes the data through unchanged and rewrites its taint under a set mask and a clear mask. One register stage follows the combinational result. It holds the data in one flip-flop and its taint in a shadow flip-flop beside it, and a synchronous reset clears both. Only one tag is tracked.

The decode is a plain opcode case with no sequencing. The only state is the output register, which has two conditions: cleared while reset is high, and loading the combinational result on every other clock.

Top module: `shadow_bitop_unit`

## Requirements
- R1: For AND (code 0) and NAND (code 11), with y = a & b or its inverse, each taint bit is (ta & (b | tb)) | (tb & (a | ta)).
- R2: For OR (code 1) and NOR (code 12), y is a | b or its inverse. The R1 masking rule is applied with both data inputs inverted, so each taint bit is (ta & (~b | tb)) | (tb & (~a | ta)).
- R3: For ANDNOT (code 2, y = a & ~b) and ORNOT (code 3, y = a | ~b), input b is inverted once more than for AND and OR before masking. ANDNOT gives (ta & (~b | tb)) | (tb & (a | ta)), and ORNOT gives (ta & (b | tb)) | (tb & (~a | ta)).
- R4: For XOR (code 4) and XNOR (code 5), each taint bit is ta | tb.
- R5: NOT (code 6, y = ~a) and BUF (code 7, y = a) pass ta to ty unchanged.
- R6: MUX (code 8) gives y = sel1 ? b : a. The single select bit sel1 and its taint ts1 are replicated across the width. Taint is (tsr & ((a ^ b) | ta | tb)) | (ta & (~sr | tsr)) | (tb & (sr | tsr)), where sr and tsr are the replicated select and select taint.
- R7: Bitwise MUX (code 9) applies the R6 rule with the per-bit select s and select taint ts.
- R8: Tag injection (code 10) gives y = a and ty = (ta & ~clr_m) | set_m, bit by bit.
- R9: Codes 13, 14 and 15 drive y and ty to zero.
- R10: q and tq take the previous cycle's y and ty on every rising clock edge. When rst is high at an edge, both registers are cleared to zero.
- R11: For every code other than 10, a taint bit is 1 exactly when some flip of tainted input bits changes that result bit. With all input taint zero, ty is zero.
- R12: The data output y equals the stated function of a, b, s and sel1 for each code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register stage |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 4 | Operation code |
| a | input | W | Operand A |
| b | input | W | Operand B |
| s | input | W | Per-bit select for code 9 |
| sel1 | input | 1 | Whole-word select for code 8 |
| ta | input | W | Taint of A |
| tb | input | W | Taint of B |
| ts | input | W | Taint of s |
| ts1 | input | 1 | Taint of sel1 |
| set_m | input | W | Taint set mask for code 10 |
| clr_m | input | W | Taint clear mask for code 10 |
| y | output | W | Combinational data result |
| ty | output | W | Combinational taint result |
| q | output | W | Registered data |
| tq | output | W | Registered taint |

## Verification
The hardest situations to reach at random are the masking corners. Both operands may be tainted in the same bit while both untainted values block each other. A tainted select may face equal untainted data inputs, where taint must appear only through a second tainted input. Purely random vectors rarely tie a to b or taint both sides together. The stimulus therefore adds phases in which b copies a, taint is made dense, and the select taint is forced on. Every result is checked against a bench model that flips each subset of tainted bits and looks for a change in the output.

// File: rtl/shadow_pkg.sv
`timescale 1ns/1ps
package shadow_pkg;

    localparam int OP_BITS = 4;

    typedef enum logic [OP_BITS-1:0] {
        OP_AND    = 4'd0,
        OP_OR     = 4'd1,
        OP_ANDNOT = 4'd2,
        OP_ORNOT  = 4'd3,
        OP_XOR    = 4'd4,
        OP_XNOR   = 4'd5,
        OP_NOT    = 4'd6,
        OP_BUF    = 4'd7,
        OP_MUX    = 4'd8,
        OP_BWMUX  = 4'd9,
        OP_TAG    = 4'd10,
        OP_NAND   = 4'd11,
        OP_NOR    = 4'd12,
        OP_RSV13  = 4'd13,
        OP_RSV14  = 4'd14,
        OP_RSV15  = 4'd15
    } op_e;

    // Input polarity applied before the AND-style masking rule
    typedef struct packed {
        logic inv_x;
        logic inv_z;
        logic inv_out;
    } andlike_cfg_t;

endpackage

// File: rtl/sb_andlike_lane.sv
`timescale 1ns/1ps
module sb_andlike_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] z,
    input  logic [W-1:0] tx,
    input  logic [W-1:0] tz,
    input  logic         inv_out,
    output logic [W-1:0] y,
    output logic [W-1:0] ty
);
    // One slice per bit: a tainted side leaks only where the other side is
    // non-blocking (1) or itself uncertain.
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic pass_x;
        logic pass_z;
        assign pass_x = x[i] | tx[i];
        assign pass_z = z[i] | tz[i];
        assign y[i]   = (x[i] & z[i]) ^ inv_out;
        assign ty[i]  = (tx[i] & pass_z) | (tz[i] & pass_x);
    end
endmodule

// File: rtl/sb_mux_lane.sv
`timescale 1ns/1ps
module sb_mux_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] sel,
    input  logic [W-1:0] ta,
    input  logic [W-1:0] tb,
    input  logic [W-1:0] tsel,
    output logic [W-1:0] y,
    output logic [W-1:0] ty
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic sel_matters;
        logic a_visible;
        logic b_visible;
        assign sel_matters = (a[i] ^ b[i]) | ta[i] | tb[i];
        assign a_visible   = ~sel[i] | tsel[i];
        assign b_visible   =  sel[i] | tsel[i];
        assign y[i]  = sel[i] ? b[i] : a[i];
        assign ty[i] = (tsel[i] & sel_matters) | (ta[i] & a_visible) | (tb[i] & b_visible);
    end
endmodule

// File: rtl/sb_tag_inject.sv
`timescale 1ns/1ps
module sb_tag_inject #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] ta,
    input  logic [W-1:0] set_m,
    input  logic [W-1:0] clr_m,
    output logic [W-1:0] y,
    output logic [W-1:0] ty
);
    assign y  = a;
    assign ty = (ta & ~clr_m) | set_m;
endmodule

// File: rtl/sb_shadow_reg.sv
`timescale 1ns/1ps
module sb_shadow_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    input  logic [W-1:0] td,
    output logic [W-1:0] q,
    output logic [W-1:0] tq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q  <= '0;
            tq <= '0;
        end else begin
            q  <= d;
            tq <= td;
        end
    end
endmodule

// File: rtl/shadow_bitop_unit.sv
`timescale 1ns/1ps
module shadow_bitop_unit
    import shadow_pkg::*;
#(
    parameter int W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [OP_BITS-1:0] op,
    input  logic [W-1:0]       a,
    input  logic [W-1:0]       b,
    input  logic [W-1:0]       s,
    input  logic               sel1,
    input  logic [W-1:0]       ta,
    input  logic [W-1:0]       tb,
    input  logic [W-1:0]       ts,
    input  logic               ts1,
    input  logic [W-1:0]       set_m,
    input  logic [W-1:0]       clr_m,
    output logic [W-1:0]       y,
    output logic [W-1:0]       ty,
    output logic [W-1:0]       q,
    output logic [W-1:0]       tq
);
    localparam logic [W-1:0] ONES = {W{1'b1}};

    op_e          opc;
    andlike_cfg_t cfg;
    logic [W-1:0] al_x, al_z, al_y, al_ty;
    logic [W-1:0] mx_sel, mx_tsel, mx_y, mx_ty;
    logic [W-1:0] tg_y, tg_ty;

    assign opc = op_e'(op);

    // Polarity set-up for the AND-style family
    always_comb begin
        cfg = '0;
        unique case (opc)
            OP_AND:    cfg = '{inv_x: 1'b0, inv_z: 1'b0, inv_out: 1'b0};
            OP_NAND:   cfg = '{inv_x: 1'b0, inv_z: 1'b0, inv_out: 1'b1};
            OP_OR:     cfg = '{inv_x: 1'b1, inv_z: 1'b1, inv_out: 1'b1};
            OP_NOR:    cfg = '{inv_x: 1'b1, inv_z: 1'b1, inv_out: 1'b0};
            OP_ANDNOT: cfg = '{inv_x: 1'b0, inv_z: 1'b1, inv_out: 1'b0};
            OP_ORNOT:  cfg = '{inv_x: 1'b1, inv_z: 1'b0, inv_out: 1'b1};
            default:   cfg = '0;
        endcase
    end

    assign al_x = cfg.inv_x ? ~a : a;
    assign al_z = cfg.inv_z ? ~b : b;

    sb_andlike_lane #(.W(W)) u_andlike (
        .x(al_x), .z(al_z), .tx(ta), .tz(tb),
        .inv_out(cfg.inv_out), .y(al_y), .ty(al_ty)
    );

    // Whole-word select is spread across every bit before the per-bit rule
    assign mx_sel  = (opc == OP_MUX) ? {W{sel1}} : s;
    assign mx_tsel = (opc == OP_MUX) ? {W{ts1}}  : ts;

    sb_mux_lane #(.W(W)) u_mux (
        .a(a), .b(b), .sel(mx_sel), .ta(ta), .tb(tb), .tsel(mx_tsel),
        .y(mx_y), .ty(mx_ty)
    );

    sb_tag_inject #(.W(W)) u_tag (
        .a(a), .ta(ta), .set_m(set_m), .clr_m(clr_m), .y(tg_y), .ty(tg_ty)
    );

    // Output selection
    always_comb begin
        y  = '0;
        ty = '0;
        unique case (opc)
            OP_AND, OP_NAND, OP_OR, OP_NOR, OP_ANDNOT, OP_ORNOT: begin
                y  = al_y;
                ty = al_ty;
            end
            OP_XOR: begin
                y  = a ^ b;
                ty = ta | tb;
            end
            OP_XNOR: begin
                y  = ~(a ^ b);
                ty = ta | tb;
            end
            OP_NOT: begin
                y  = a ^ ONES;
                ty = ta;
            end
            OP_BUF: begin
                y  = a;
                ty = ta;
            end
            OP_MUX, OP_BWMUX: begin
                y  = mx_y;
                ty = mx_ty;
            end
            OP_TAG: begin
                y  = tg_y;
                ty = tg_ty;
            end
            default: begin
                y  = '0;
                ty = '0;
            end
        endcase
    end

    sb_shadow_reg #(.W(W)) u_reg (
        .clk(clk), .rst(rst), .d(y), .td(ty), .q(q), .tq(tq)
    );

    AST_REG_CLEAR: assert property (@(posedge clk)
        rst |=> (q == '0 && tq == '0)); // R10

    AST_REG_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (q == $past(y) && tq == $past(ty))); // R10

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op >= 4'd13) |-> (y == '0 && ty == '0)); // R9

    AST_TRANSPARENT_TAINT: assert property (@(posedge clk) disable iff (rst)
        (op == 4'd6 || op == 4'd7) |-> (ty == ta)); // R5

    AST_TAG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (op == 4'd10) |-> ((ty & set_m) == set_m && y == a)); // R8

    AST_CLEAN_STAYS_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (op != 4'd10 && ta == '0 && tb == '0 && ts == '0 && !ts1) |-> (ty == '0)); // R11

    AST_XOR_UNION: assert property (@(posedge clk) disable iff (rst)
        (op == 4'd4 || op == 4'd5) |-> ((ty & (ta | tb)) == (ta | tb))); // R4
endmodule

// File: tb/shadow_bitop_unit_test.sv
`timescale 1ns/1ps
module shadow_bitop_unit_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   op = '0;
    logic [W-1:0] a = '0, b = '0, s = '0, ta = '0, tb = '0, ts = '0;
    logic [W-1:0] set_m = '0, clr_m = '0;
    logic         sel1 = 1'b0, ts1 = 1'b0;
    logic [W-1:0] y, ty, q, tq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [W-1:0] pend_q = '0, pend_tq = '0;

    always #2 clk = ~clk;

    shadow_bitop_unit #(.W(W)) uut (
        .clk(clk), .rst(rst), .op(op), .a(a), .b(b), .s(s), .sel1(sel1),
        .ta(ta), .tb(tb), .ts(ts), .ts1(ts1), .set_m(set_m), .clr_m(clr_m),
        .y(y), .ty(ty), .q(q), .tq(tq)
    );

    function automatic bit ev(int o, bit xa, bit xb, bit xs);
        case (o)
            0:  return xa & xb;
            1:  return xa | xb;
            2:  return xa & ~xb;
            3:  return xa | ~xb;
            4:  return xa ^ xb;
            5:  return ~(xa ^ xb);
            6:  return ~xa;
            7:  return xa;
            8, 9: return xs ? xb : xa;
            11: return ~(xa & xb);
            12: return ~(xa | xb);
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(int o);
        case (o)
            0, 11: return "R1";
            1, 12: return "R2";
            2, 3:  return "R3";
            4, 5:  return "R4";
            6, 7:  return "R5";
            8:     return "R6";
            9:     return "R7";
            10:    return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s op=%0d actual=%h expected=%h", req, op, act, exp);
        end
    endtask

    // One vector: registered check from the previous vector, then combinational
    task automatic apply(int o, logic [W-1:0] va, vb, vs, vta, vtb, vts,
                         bit vsel, bit vts1, logic [W-1:0] vset, vclr, bit vrst);
        logic [W-1:0] ey, ety;
        @(negedge clk);
        check("R10 q", q, pend_q);
        check("R10 tq", tq, pend_tq);
        op = 4'(o); a = va; b = vb; s = vs; ta = vta; tb = vtb; ts = vts;
        sel1 = vsel; ts1 = vts1; set_m = vset; clr_m = vclr; rst = vrst;
        #1;
        ey = '0; ety = '0;
        for (int i = 0; i < W; i++) begin
            bit bs, tsb, base;
            bs  = (o == 8) ? vsel : vs[i];
            tsb = (o == 8) ? vts1 : vts[i];
            if (o == 10) begin
                ey[i]  = va[i];
                ety[i] = (vta[i] & ~vclr[i]) | vset[i];
            end else if (o <= 12) begin
                base  = ev(o, va[i], vb[i], bs);
                ey[i] = base;
                for (int m = 1; m < 8; m++) begin
                    bit fa, fb, fs;
                    fa = m[0] & vta[i];
                    fb = m[1] & vtb[i];
                    fs = m[2] & tsb;
                    if (ev(o, va[i] ^ fa, vb[i] ^ fb, bs ^ fs) != base) ety[i] = 1'b1;
                end
            end
        end
        check({"R12/", req_of(o)}, y, ey);
        check((o == 10 || o > 12) ? req_of(o) : {"R11/", req_of(o)}, ty, ety);
        pend_q  = vrst ? '0 : ey;
        pend_tq = vrst ? '0 : ety;
    endtask

    function automatic logic [W-1:0] rnd();
        return W'($urandom);
    endfunction

    initial begin
        #400000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset q", q, '0);
        check("R10 reset tq", tq, '0);

        // Directed corners
        apply(0, 16'h00FF, 16'h0F0F, '0, 16'hFFFF, '0, '0, 0, 0, '0, '0, 0); // R1 ta masked by b
        apply(0, 16'h0000, 16'h0000, '0, 16'hF0F0, 16'hFF00, '0, 0, 0, '0, '0, 0); // R1 both tainted
        apply(1, 16'hFFFF, 16'h00F0, '0, '0, 16'hFFFF, '0, 0, 0, '0, '0, 0); // R2 a=1 blocks tb
        apply(2, 16'h0F0F, 16'h3333, '0, 16'hFFFF, 16'hFFFF, '0, 0, 0, '0, '0, 0); // R3
        apply(3, 16'hAAAA, 16'h5555, '0, 16'h0FF0, '0, '0, 0, 0, '0, '0, 0); // R3
        apply(4, 16'h1234, 16'h4321, '0, 16'h000F, 16'hF000, '0, 0, 0, '0, '0, 0); // R4
        apply(6, 16'h1234, '0, '0, 16'h8001, 16'hFFFF, '0, 0, 0, '0, '0, 0); // R5
        apply(8, 16'hABCD, 16'hABCD, '0, '0, '0, '0, 1, 1, '0, '0, 0); // R6 equal data, tainted sel
        apply(8, 16'hABCD, 16'h1234, '0, 16'hFFFF, 16'h0000, '0, 1, 0, '0, '0, 0); // R6 a hidden
        apply(9, 16'hFF00, 16'hF0F0, 16'hCCCC, 16'h00FF, 16'hFF00, 16'hAAAA, 0, 0, '0, '0, 0); // R7
        apply(10, 16'hBEEF, '0, '0, 16'hFF00, '0, '0, 0, 0, 16'h000F, 16'hF0F0, 0); // R8
        apply(13, 16'hFFFF, 16'hFFFF, '0, 16'hFFFF, 16'hFFFF, '0, 0, 0, '0, '0, 0); // R9
        apply(15, 16'h1111, 16'h2222, '0, 16'hFFFF, '0, '0, 0, 0, '0, '0, 1); // R10 reset mid-run
        apply(7, 16'h5A5A, '0, '0, 16'h0F0F, '0, '0, 0, 0, '0, '0, 0);

        // Random over every code, sparse taint
        for (int k = 0; k < 1600; k++)
            apply(k % 16, rnd(), rnd(), rnd(), rnd() & rnd(), rnd() & rnd(), rnd() & rnd(),
                  1'($urandom), 1'($urandom), rnd() & rnd(), rnd(), ($urandom % 97) == 0);

        // Hard corners: b copies a, dense taint, forced select taint
        for (int k = 0; k < 800; k++) begin
            logic [W-1:0] va;
            va = rnd();
            apply(k % 13, va, (k % 3 == 0) ? va : ~va, rnd(), rnd() | rnd(), rnd() | rnd(),
                  rnd() | rnd(), 1'($urandom), 1'b1, rnd(), rnd(), 0);
        end

        // Untainted inputs must produce no taint (R11)
        for (int k = 0; k < 200; k++)
            apply(k % 13, rnd(), rnd(), rnd(), '0, '0, '0, 1'($urandom), 1'b0, '0, '0, 0);

        @(negedge clk);
        check("R10 q", q, pend_q);
        check("R10 tq", tq, pend_tq);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule